// File: doc/BRIEF.md
# Gated Pulse-Count Frequency Digitiser

This block turns an incoming pulse train into a digital word by counting the train's rising edges over a fixed gate window. The window is produced by dividing the block's own clock with a binary counter. When the same clock also drives the circuit that makes the pulses, the result depends only on the ratio of the pulse rate to the clock rate, so drift of the clock cancels out.

A host pulses `start` once. The gate then stays open for 2^GATE_LOG2 clock cycles. The gate length is chosen to reach a given resolution: the full-scale count equals the gate length times the maximum pulse rate. It can also be set to a whole number of periods of an interferer, such as mains hum, so that the interferer is rejected. The pulse input is asynchronous to the clock. It first passes a two-flop synchroniser and then a rising-edge detector. Because the gate is not aligned to the pulses, any result may be off by one count.

When the gate closes, the block registers the raw count and an offset-removed count, and raises `done` for one cycle. The offset is the count expected at zero scale, which corresponds to a pulse rate of 5% of the clock rate.

Top module: `pulse_gate_counter`

## Requirements
- R1: After reset, `count_o` and `net_o` are 0 and `done_o` is 0.
- R2: Suppose a `start` that is accepted is sampled at clock edge k. Then `done_o` is 1 for exactly one cycle, starting after edge k+2^GATE_LOG2.
- R3: `count_o` equals the number of pulse-input rising edges that fall inside the gate, to within plus or minus one count. Each high phase and each low phase of the pulse input must last at least two clock periods. `count_o` is GATE_LOG2+1 bits wide and never wraps.
- R4: A pulse input held constant at 1 or at 0 for the whole gate gives a count of 0.
- R5: A `start` that arrives while a gate is open is ignored. It neither moves the end of the gate nor produces a second `done_o`.
- R6: `net_o` equals `count_o` minus Z, or 0 if `count_o` is less than Z. Z = floor(2^GATE_LOG2 * 5 / 100), which is 12 for the default value of 8.
- R7: `count_o` and `net_o` keep their values between gates and change only in the cycle in which `done_o` is 1.
- R8: Each accepted `start` clears the running count, so a result never includes edges from an earlier gate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock; also the timebase of the gate |
| rst | input | 1 | Synchronous active-high reset |
| pulse_in | input | 1 | Asynchronous pulse train to be counted |
| start | input | 1 | Opens a gate if none is open |
| count_o | output | GATE_LOG2+1 | Raw edge count of the last gate |
| net_o | output | GATE_LOG2+1 | Count with the zero-scale offset removed, floored at 0 |
| done_o | output | 1 | One-cycle pulse when a new result is present |

## Verification
The hardest case to reach is a pulse edge that lands near a clock edge right at the opening or the closing of the gate, because that is where the one-count uncertainty comes from. The stimulus runs the pulse source from its own timer, with fractional-nanosecond periods drawn at random. This makes the edge phase slide against the clock from one gate to the next, and each result is accepted if it lies within one count of the ideal ratio. Directed cases cover the other situations: a constant level, a second `start` partway through an open gate, back-to-back gates with and without pulses, and low counts that drive the offset subtraction down to its floor.

// File: rtl/pgc_pkg.sv
package pgc_pkg;

    typedef enum logic {
        GATE_IDLE = 1'b0,
        GATE_OPEN = 1'b1
    } gate_state_e;

    // Count expected over a gate when the pulse rate is 5% of the clock rate.
    function automatic int unsigned zero_scale_count(input int unsigned log2_len);
        return ((32'd1 << log2_len) * 32'd5) / 32'd100;
    endfunction

endpackage

// File: rtl/pgc_edge_sync.sv
module pgc_edge_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_i,
    output logic rise_o
);
    // Index 0 takes the raw input; index STAGES keeps the previous synchronised value.
    logic [STAGES:0] chain_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[STAGES-1:0], async_i};
        end
    end

    assign rise_o = chain_q[STAGES-1] & ~chain_q[STAGES];

endmodule

// File: rtl/pgc_gate_timer.sv
module pgc_gate_timer
    import pgc_pkg::*;
#(
    parameter int unsigned GATE_LOG2 = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic start_i,
    output logic accept_o,
    output logic open_o,
    output logic close_o
);
    gate_state_e          state_q;
    logic [GATE_LOG2-1:0] tick_q;

    assign open_o   = (state_q == GATE_OPEN);
    assign accept_o = start_i && !open_o;
    assign close_o  = open_o && (tick_q == '1);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= GATE_IDLE;
            tick_q  <= '0;
        end else if (accept_o) begin
            state_q <= GATE_OPEN;
            tick_q  <= '0;
        end else if (open_o) begin
            tick_q <= tick_q + 1'b1;
            if (close_o) begin
                state_q <= GATE_IDLE;
            end
        end
    end

endmodule

// File: rtl/pgc_edge_accum.sv
module pgc_edge_accum #(
    parameter int unsigned CNT_W = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear_i,
    input  logic             en_i,
    input  logic             rise_i,
    output logic [CNT_W-1:0] total_o
);
    logic [CNT_W-1:0] acc_q;
    logic             hit;

    assign hit     = en_i && rise_i;
    assign total_o = acc_q + CNT_W'(hit);

    always_ff @(posedge clk) begin
        if (rst || clear_i) begin
            acc_q <= '0;
        end else if (hit) begin
            acc_q <= acc_q + 1'b1;
        end
    end

endmodule

// File: rtl/pulse_gate_counter.sv
module pulse_gate_counter
    import pgc_pkg::*;
#(
    parameter int unsigned GATE_LOG2   = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 pulse_in,
    input  logic                 start,
    output logic [GATE_LOG2:0]   count_o,
    output logic [GATE_LOG2:0]   net_o,
    output logic                 done_o
);
    localparam int unsigned CNT_W = GATE_LOG2 + 1;
    localparam logic [CNT_W-1:0] ZERO_CNT = CNT_W'(zero_scale_count(GATE_LOG2));

    typedef struct packed {
        logic [CNT_W-1:0] raw;
        logic [CNT_W-1:0] net;
    } result_t;

    logic             rise;
    logic             accept;
    logic             gate_open;
    logic             gate_close;
    logic [CNT_W-1:0] total;
    result_t          result_q;
    logic             done_q;

    pgc_edge_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk     (clk),
        .rst     (rst),
        .async_i (pulse_in),
        .rise_o  (rise)
    );

    pgc_gate_timer #(.GATE_LOG2(GATE_LOG2)) timer_i (
        .clk      (clk),
        .rst      (rst),
        .start_i  (start),
        .accept_o (accept),
        .open_o   (gate_open),
        .close_o  (gate_close)
    );

    pgc_edge_accum #(.CNT_W(CNT_W)) accum_i (
        .clk     (clk),
        .rst     (rst),
        .clear_i (accept),
        .en_i    (gate_open),
        .rise_i  (rise),
        .total_o (total)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            result_q <= '0;
            done_q   <= 1'b0;
        end else begin
            done_q <= gate_close;
            if (gate_close) begin
                result_q.raw <= total;
                result_q.net <= (total > ZERO_CNT) ? (total - ZERO_CNT) : '0;
            end
        end
    end

    assign count_o = result_q.raw;
    assign net_o   = result_q.net;
    assign done_o  = done_q;

endmodule

// File: rtl/pgc_checker.sv
module pgc_checker #(
    parameter int unsigned GATE_LOG2 = 8
) (
    input logic               clk,
    input logic               rst,
    input logic               start,
    input logic               done_o,
    input logic [GATE_LOG2:0] count_o,
    input logic [GATE_LOG2:0] net_o
);
    localparam int unsigned GATE = 1 << GATE_LOG2;
    localparam int unsigned CW   = GATE_LOG2 + 2;

    logic          busy_q;
    logic [CW-1:0] cyc_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            cyc_q  <= '0;
        end else if (start && (!busy_q || done_o)) begin
            busy_q <= 1'b1;
            cyc_q  <= '0;
        end else if (done_o) begin
            busy_q <= 1'b0;
        end else if (busy_q) begin
            cyc_q <= cyc_q + 1'b1;
        end
    end

    p_gate_len_r2: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (busy_q && cyc_q == CW'(GATE)));

    p_done_pulse_r2: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
        32'(count_o) <= (GATE / 2 + 1));

    p_net_le_r6: assert property (@(posedge clk) disable iff (rst)
        net_o <= count_o);

    p_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !done_o |-> ($stable(count_o) && $stable(net_o)));

endmodule

bind pulse_gate_counter pgc_checker #(.GATE_LOG2(GATE_LOG2)) chk_i (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .done_o  (done_o),
    .count_o (count_o),
    .net_o   (net_o)
);

// File: tb/pulse_gate_counter_tb_top.sv
`timescale 1ns/1ps
module pulse_gate_counter_tb_top;
    localparam int unsigned LOG2  = 8;
    localparam int unsigned GATE  = 1 << LOG2;
    localparam int unsigned ZERO  = (GATE * 5) / 100;
    localparam real         TCLK  = 4.0;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           pulse_in = 1'b0;
    logic           start = 1'b0;
    logic [LOG2:0]  count_o;
    logic [LOG2:0]  net_o;
    logic           done_o;

    int  n_chk = 0;
    int  n_bad = 0;
    real per_ns = 0.0;
    logic hold_lvl = 1'b0;
    int  last_cnt;

    always #2 clk = ~clk;

    pulse_gate_counter #(.GATE_LOG2(LOG2)) dut_i (
        .clk(clk), .rst(rst), .pulse_in(pulse_in), .start(start),
        .count_o(count_o), .net_o(net_o), .done_o(done_o)
    );

    // Free-running pulse source, asynchronous to the clock.
    initial begin
        forever begin
            if (per_ns <= 0.0) begin
                pulse_in = hold_lvl;
                #1;
            end else begin
                pulse_in = 1'b1;
                #(per_ns / 2.0);
                pulse_in = 1'b0;
                #(per_ns / 2.0);
            end
        end
    end

    function automatic int exp_net(input int raw);
        return (raw > ZERO) ? raw - ZERO : 0;
    endfunction

    task automatic check(input string req, input bit ok, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // Runs one gate, checks R2 timing, returns the raw count.
    task automatic run_gate(input bit mid_start, output int raw);
        @(negedge clk); start = 1'b1;
        @(posedge clk);
        @(negedge clk); start = 1'b0;
        for (int i = 1; i < GATE; i++) begin
            @(posedge clk);
            @(negedge clk);
            if (mid_start && i == GATE / 2) start = 1'b1;
            else start = 1'b0;
            check("R2 done early", done_o == 1'b0, done_o, 0);
        end
        @(posedge clk);
        @(negedge clk);
        check("R2 done at gate end", done_o == 1'b1, done_o, 1);
        raw = count_o;
        check("R6 net", net_o == exp_net(raw), net_o, exp_net(raw));
        @(negedge clk);
        check("R2 done one cycle", done_o == 1'b0, done_o, 0);
    endtask

    task automatic rate_gate(input real p, input string tag);
        int  raw;
        real ideal;
        per_ns = p;
        repeat (20) @(posedge clk);
        run_gate(1'b0, raw);
        ideal = (GATE * TCLK) / p;
        check(tag, (raw >= ideal - 1.0) && (raw <= ideal + 1.0), raw, int'(ideal));
    endtask

    initial begin
        int raw;
        void'($urandom(32'h5EED_0042));
        repeat (4) @(posedge clk);
        @(negedge clk);
        check("R1 count", count_o == 0, count_o, 0);
        check("R1 net", net_o == 0, net_o, 0);
        check("R1 done", done_o == 0, done_o, 0);
        rst = 1'b0;

        // R4: constant levels give no edges
        hold_lvl = 1'b1; per_ns = 0.0;
        repeat (10) @(posedge clk);
        run_gate(1'b0, raw);
        check("R4 held high", raw == 0, raw, 0);
        hold_lvl = 1'b0;
        repeat (10) @(posedge clk);
        run_gate(1'b0, raw);
        check("R4 held low", raw == 0, raw, 0);

        // R3 directed: fastest allowed and a slow rate
        rate_gate(17.3, "R3 fast");
        rate_gate(97.1, "R3 slow");
        // R6 floor: count below Z
        rate_gate(150.0, "R3 R6 low count");

        // R5: second start mid-gate is ignored
        per_ns = 40.3;
        repeat (10) @(posedge clk);
        run_gate(1'b1, raw);
        check("R5 count", (raw >= 24) && (raw <= 27), raw, 25);
        for (int i = 0; i < GATE + 8; i++) begin
            @(negedge clk);
            check("R5 no second done", done_o == 1'b0, done_o, 0);
        end

        // R7: result holds while the input keeps toggling
        last_cnt = count_o;
        per_ns = 23.7;
        repeat (60) @(posedge clk);
        @(negedge clk);
        check("R7 hold", count_o == last_cnt, count_o, last_cnt);

        // R8: a quiet gate after a busy one reads zero
        run_gate(1'b0, raw);
        per_ns = 0.0; hold_lvl = 1'b0;
        repeat (10) @(posedge clk);
        run_gate(1'b0, raw);
        check("R8 cleared", raw == 0, raw, 0);

        // R3 random rates
        for (int k = 0; k < 24; k++) begin
            real p;
            p = 17.0 + real'($urandom % 1800) / 10.0;
            rate_gate(p, "R3 random");
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule